// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block is the device-side serial front end of a 16-bit digital-to-analog converter. A host frames each write by pulling chip-select low, then presents one data bit per serial clock. The bits are sampled on the rising serial clock edge, most significant bit first, into a shift register. When chip-select returns high, the received word is copied into an input register. A separate load strobe later copies the input register into the output latch, and that latch drives the converter code. Several converters can therefore be written one after another and then updated together.

All pins are sampled by a fast system clock. Each pin passes through a synchronizer and an edge detector, so the whole block runs in one clock domain. The system clock must run at least four times faster than the serial clock. A frame with more than sixteen clocks keeps only the last sixteen bits. A frame with fewer than sixteen clocks is thrown away. A reset input clears every register. A power-down input is reported on a status flag and does not block serial writes.

Top module: `dac_serif_top`

## Requirements
- R1: While `rst` is high, the output code, the input register and the shift register are cleared to zero. A load strobe issued after reset therefore presents code 0x0000.
- R2: A frame of exactly sixteen rising `sclk` edges with `cs_n` low, followed by a rising `cs_n` and a falling `ldac_n`, presents the sixteen bits on `dac_code`. The first bit received becomes bit 15.
- R3: A frame with more than sixteen rising `sclk` edges keeps the last sixteen bits. The bit taken on the final edge becomes bit 0.
- R4: A frame with fewer than sixteen rising `sclk` edges leaves the input register unchanged. A later load presents the previous word.
- R5: A rising `cs_n` alone does not change `dac_code`. The code changes only when a load strobe follows.
- R6: `dac_code` takes the input register only on a falling edge of `ldac_n`. A rising edge of `ldac_n` has no effect.
- R7: `pd_flag` follows the `pd` input. While `pd` is high, frames and loads still update `dac_code`.
- R8: A falling `ldac_n` that occurs while `rst` is high does not load anything. `dac_code` stays 0x0000.
- R9: A falling `cs_n` starts a new word. Clocks from an earlier aborted frame do not count toward the sixteen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; pins are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low, frames a word |
| sclk | input | 1 | Serial clock, data sampled on rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| ldac_n | input | 1 | Load strobe, falling edge updates the output latch |
| pd | input | 1 | Hardware power-down request |
| dac_code | output | 16 | Output latch code to the converter |
| pd_flag | output | 1 | Power-down status |

## Verification
The bench sends frames of 16, 20, 9 and 7 clocks and compares the loaded code with a reference model. A design that keeps the first sixteen bits, or one that commits a short frame, shows a wrong code at the next load. The bench checks the output right after chip-select rises and again after a rising load edge. This catches a design that merges the two stages, or one that loads on the wrong edge. It also raises reset together with a falling load strobe, sends a power-down-time write, and sends a short frame followed at once by a full frame. A design that lets reset lose priority, blocks writes in power-down, or carries a bit count across frames fails one of these checks.

// File: rtl/dac_serif_pkg.sv
package dac_serif_pkg;
  // Pin order inside the synchronizer bank
  localparam int PIN_SCLK = 0;
  localparam int PIN_CS   = 1;
  localparam int PIN_SDI  = 2;
  localparam int PIN_LDAC = 3;
  localparam int PIN_PD   = 4;
  localparam int N_PINS   = 5;
  // Idle level of each pin: chip-select and load strobe idle high
  localparam logic [N_PINS-1:0] PIN_IDLE = 5'b01010;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } pin_evt_t;
endpackage

// File: rtl/dac_serif_sync.sv
module dac_serif_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pin,
  output dac_serif_pkg::pin_evt_t   evt
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  always_comb begin
    evt.lvl  = chain[STAGES-1];
    evt.rise = chain[STAGES-1] & ~prev;
    evt.fall = ~chain[STAGES-1] & prev;
  end

  a_r1_idle_after_reset : assert property (@(posedge clk)
    rst |=> (evt.lvl == RST_VAL) && !evt.rise && !evt.fall);
endmodule

// File: rtl/dac_serif_shift.sv
module dac_serif_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sdi_lvl,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      cnt    <= '0;
      commit <= 1'b0;
    end else begin
      commit <= cs_rise && (cnt == FULL);
      if (cs_fall) begin
        cnt <= '0;
      end else if (sclk_rise && !cs_lvl) begin
        sh <= {sh[WORD_W-2:0], sdi_lvl};
        if (cnt != FULL) cnt <= cnt + 1'b1;
      end
    end
  end

  assign word = sh;

  // R3: count saturates at the word length; extra clocks only slide the window
  a_r3_count_saturates : assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  // R9: a new frame starts counting from zero
  a_r9_frame_restart : assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> cnt == '0);
endmodule

// File: rtl/dac_serif_latch.sv
module dac_serif_latch #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  input  logic              ld_fall,
  input  logic              pd_lvl,
  output logic [WORD_W-1:0] code,
  output logic              pd_flag
);
  logic [WORD_W-1:0] in_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_reg  <= '0;
      code    <= '0;
      pd_flag <= 1'b0;
    end else begin
      pd_flag <= pd_lvl;
      if (commit)  in_reg <= word;
      if (ld_fall) code   <= in_reg;
    end
  end

  a_r1_reset_clears : assert property (@(posedge clk)
    rst |=> (code == '0) && (in_reg == '0));
  a_r4_input_holds : assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(in_reg));
  a_r6_code_only_on_load : assert property (@(posedge clk) disable iff (rst)
    !ld_fall |=> $stable(code));
  a_r7_pd_tracks : assert property (@(posedge clk) disable iff (rst)
    pd_lvl |=> pd_flag);
endmodule

// File: rtl/dac_serif_top.sv
module dac_serif_top #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              ldac_n,
  input  logic              pd,
  output logic [WORD_W-1:0] dac_code,
  output logic              pd_flag
);
  import dac_serif_pkg::*;

  logic [N_PINS-1:0] pins;
  pin_evt_t          evt [N_PINS];
  logic              commit;
  logic [WORD_W-1:0] word;

  always_comb begin
    pins           = '0;
    pins[PIN_SCLK] = sclk;
    pins[PIN_CS]   = cs_n;
    pins[PIN_SDI]  = sdi;
    pins[PIN_LDAC] = ldac_n;
    pins[PIN_PD]   = pd;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_sync
    dac_serif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE[i])) u_sync (
      .clk (clk),
      .rst (rst),
      .pin (pins[i]),
      .evt (evt[i])
    );
  end

  dac_serif_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_lvl    (evt[PIN_CS].lvl),
    .cs_fall   (evt[PIN_CS].fall),
    .cs_rise   (evt[PIN_CS].rise),
    .sclk_rise (evt[PIN_SCLK].rise),
    .sdi_lvl   (evt[PIN_SDI].lvl),
    .commit    (commit),
    .word      (word)
  );

  dac_serif_latch #(.WORD_W(WORD_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .word    (word),
    .ld_fall (evt[PIN_LDAC].fall),
    .pd_lvl  (evt[PIN_PD].lvl),
    .code    (dac_code),
    .pd_flag (pd_flag)
  );

  // R5: the input register is committed only as a result of a chip-select rise
  a_r5_commit_from_cs : assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(evt[PIN_CS].rise));
endmodule

// File: tb/dac_serif_top_bench.sv
module dac_serif_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;   // system clocks per serial half period
  localparam int SETTLE     = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ldac_n = 1'b1, pd = 1'b0;
  logic [15:0] dac_code;
  logic pd_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] code;
    logic        pdf;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [15:0] in_m  = '0;
  logic [15:0] out_m = '0;
  logic        pd_m  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_serif_top u_dac_serif_top (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .ldac_n(ldac_n), .pd(pd), .dac_code(dac_code), .pd_flag(pd_flag)
  );

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: frames a word of n bits, MSB of the n first
  task automatic send(logic [31:0] val, int n);
    cs_n = 1'b0; wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; sdi = val[i]; wait_clk(HALF);
      sclk = 1'b1; wait_clk(HALF);
    end
    sclk = 1'b0; wait_clk(HALF);
    cs_n = 1'b1; wait_clk(SETTLE);
    if (n >= 16) in_m = val[15:0];
  endtask

  task automatic load();
    ldac_n = 1'b0; wait_clk(SETTLE);
    ldac_n = 1'b1; wait_clk(SETTLE);
    out_m = in_m;
  endtask

  task automatic expect_now(string tag);
    exp_t e;
    e.code = out_m; e.pdf = pd_m; e.tag = tag;
    q.push_back(e);
    wait_clk(2);
  endtask

  // monitor: pops expected items and compares them with the ports
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (dac_code !== e.code || pd_flag !== e.pdf) begin
        errors++;
        $display("FAIL %s: code=%h pd_flag=%b expected code=%h pd_flag=%b",
                 e.tag, dac_code, pd_flag, e.code, e.pdf);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst = 1'b0; wait_clk(SETTLE);
    expect_now("R1 reset state");
    load();
    expect_now("R1 load after reset gives zero");

    send(32'h0000_A5C3, 16);
    expect_now("R5 cs rise alone keeps code");
    load();
    expect_now("R2 exact 16-bit frame");

    send(32'h0000_1234, 16); load();
    expect_now("R2 second pattern");

    send(32'h000F_BEEF, 20); load();
    expect_now("R3 long frame keeps last 16");

    send(32'h0000_01FF, 9); load();
    expect_now("R4 short frame discarded");

    // R6: falling load updates, rising load does nothing
    send(32'h0000_7E81, 16);
    ldac_n = 1'b0; wait_clk(SETTLE); out_m = in_m;
    expect_now("R6 falling load edge");
    send(32'h0000_C0DE, 16);
    ldac_n = 1'b1; wait_clk(SETTLE);
    expect_now("R6 rising load edge ignored");
    ldac_n = 1'b0; wait_clk(SETTLE); out_m = in_m;
    expect_now("R6 next falling edge loads");
    ldac_n = 1'b1; wait_clk(SETTLE);

    // R7: power-down reported, writes still accepted
    pd = 1'b1; wait_clk(SETTLE); pd_m = 1'b1;
    expect_now("R7 pd flag set");
    send(32'h0000_55AA, 16); load();
    expect_now("R7 write during power-down");
    pd = 1'b0; wait_clk(SETTLE); pd_m = 1'b0;
    expect_now("R7 pd flag clear");

    // R9: aborted frame then full frame
    send(32'h0000_0055, 7);
    send(32'h0000_9A3C, 16); load();
    expect_now("R9 new frame restarts count");

    // R8: reset with a falling load strobe
    send(32'h0000_FFFF, 16);
    rst = 1'b1; ldac_n = 1'b0; wait_clk(4);
    in_m = '0; out_m = '0;
    rst = 1'b0; wait_clk(SETTLE);
    expect_now("R8 reset beats load");
    ldac_n = 1'b1; wait_clk(SETTLE);
    load();
    expect_now("R1 input register cleared by reset");

    wait_clk(4);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule